// File: doc/BRIEF.md
# Timestamped Read Frame Packer

This block turns one device sample at a time into a read-channel frame and streams it out one byte per transfer. A frame request names the source device and gives the sample length in bytes. Once the request is accepted, the block sends a 16-byte header: the device address, the 64-bit common timestamp and the reported sample size. It then passes the sample bytes through from a byte input and appends 0xFF filler bytes, so that the reported size and the frame as a whole fall on the transmit word boundary. The transmit word width is set by the `ALIGN_BITS` parameter.

The block also holds the shared acquisition counter that supplies the timestamp. While the block is running, the counter advances once for every acquisition tick. A two-bit command can clear it, either leaving the running state as it is or starting the block in the same step. A separate write sets or clears the running state directly. When the block is stopped, the counter holds its value and no new frame is accepted. The counter value in the cycle a request is accepted is the one placed in that frame.

Top module: `rd_frame_packer`

## Requirements
- R1: Header bytes leave in this order. Bytes 0 to 3 carry the device address, bytes 4 to 11 the timestamp and bytes 12 to 15 the size field. Each field is sent least-significant byte first.
- R2: The size field equals `req_len` rounded up to the next multiple of `ALIGN_BITS/8` bytes.
- R3: After the sample come (A - len mod A) mod A bytes of value 0xFF, where A = `ALIGN_BITS/8`. A frame is therefore exactly 16 + size-field bytes long, and `o_last` is high only on its final byte.
- R4: Exactly `req_len` payload bytes are taken from `pl_data` for each frame and passed to `o_data` in order, unchanged. `pl_ready` is never high while `o_ready` is low.
- R5: The timestamp field equals the value of `ts_now` in the cycle where `req_valid` and `req_ready` were both high.
- R6: While `running` is 1, `ts_now` grows by exactly one on every clock where `acq_tick` is 1. Otherwise it holds.
- R7: A command with `cnt_cmd_valid`=1 and `cnt_cmd`=1 sets `ts_now` to 0 on the next clock and leaves `running` unchanged.
- R8: A command with `cnt_cmd`=2 sets `ts_now` to 0 and `running` to 1 on the same clock.
- R9: While `running` is 0, `req_ready` stays low and no new frame starts. `ts_now` also holds, whatever `acq_tick` does.
- R10: Once `o_valid` is high with `o_ready` low, `o_valid` stays high on the next clock and `o_data` does not change. This holds provided the payload source keeps its own offer steady.
- R11: After reset, `running` is 0, `ts_now` is 0 and `o_valid` is 0.
- R12: Command codes 0 and 3 change neither `ts_now` nor `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_tick | input | 1 | One acquisition-clock period has elapsed |
| run_wr_en | input | 1 | Write strobe for the running state |
| run_wr_val | input | 1 | New running state |
| cnt_cmd_valid | input | 1 | Counter command strobe |
| cnt_cmd | input | 2 | Counter command: 1 clears the counter, 2 clears it and starts running |
| running | output | 1 | Current running state |
| ts_now | output | 64 | Current common timestamp |
| req_valid | input | 1 | Frame request offered |
| req_ready | output | 1 | Frame request accepted |
| req_addr | input | 32 | Source device address |
| req_len | input | LEN_W | Sample length in bytes |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| o_valid | output | 1 | Output byte offered |
| o_ready | input | 1 | Output byte taken downstream |
| o_data | output | 8 | Output byte |
| o_last | output | 1 | Final byte of the frame |

## Verification
On every cycle the assertions check the counter rules: the increment, the hold while stopped, both clear commands, and the refusal of requests while stopped. They also check that a stalled output byte is held, that `o_last` never appears without `o_valid`, and that payload is only taken when the output can take it. Byte order inside the header, the rounded size field, the filler bytes, the timestamp captured at acceptance and the exact frame length cannot be seen on the ports in a single cycle. The bench shows these by rebuilding each expected frame from the request and comparing it with what was collected, over directed lengths around the word boundary and random lengths with random stalls on both sides.

// File: rtl/frame_pkg.sv
package frame_pkg;
   localparam int HDR_BYTES = 16;
   localparam int TS_W      = 64;
   localparam int ADDR_W    = 32;
   localparam int SIZE_W    = 32;

   localparam logic [1:0] CMD_CLEAR     = 2'd1;
   localparam logic [1:0] CMD_CLEAR_RUN = 2'd2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HDR  = 2'd1,
      PH_DATA = 2'd2,
      PH_PAD  = 2'd3
   } phase_t;
endpackage

// File: rtl/acq_timebase.sv
module acq_timebase
   import frame_pkg::*;
#(
   parameter int CNT_W = TS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acq_tick,
   input  logic             run_wr_en,
   input  logic             run_wr_val,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_code,
   output logic             running,
   output logic [CNT_W-1:0] count
);
   logic do_clear;
   logic do_start;

   always_comb begin
      do_start = cmd_valid && (cmd_code == CMD_CLEAR_RUN);
      do_clear = cmd_valid && ((cmd_code == CMD_CLEAR) || (cmd_code == CMD_CLEAR_RUN));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         count   <= '0;
      end else begin
         if (do_start)       running <= 1'b1;
         else if (run_wr_en) running <= run_wr_val;

         if (do_clear)                 count <= '0;
         else if (running && acq_tick) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/pad_calc.sv
module pad_calc #(
   parameter int ALIGN_BITS = 32,
   parameter int LEN_W      = 16
) (
   input  logic [LEN_W-1:0] len,
   output logic [3:0]       pad_bytes,
   output logic [LEN_W:0]   padded_len
);
   localparam int ALIGN_BYTES = ALIGN_BITS / 8;
   localparam int AL_LOG      = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;

   generate
      if (ALIGN_BYTES == 1) begin : g_byte_aligned
         assign pad_bytes = 4'd0;
      end else begin : g_word_aligned
         logic [LEN_W-1:0] neg_len;
         assign neg_len   = '0 - len;
         assign pad_bytes = 4'(neg_len[AL_LOG-1:0]);
      end
   endgenerate

   assign padded_len = {1'b0, len} + (LEN_W+1)'(pad_bytes);
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
   import frame_pkg::*;
#(
   parameter int ALIGN_BITS = 32,
   parameter int LEN_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic [TS_W-1:0]   ts_in,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              pl_valid,
   output logic              pl_ready,
   input  logic [7:0]        pl_data,
   output logic              o_valid,
   input  logic              o_ready,
   output logic [7:0]        o_data,
   output logic              o_last
);
   localparam int HDR_W   = ADDR_W + TS_W + SIZE_W;
   localparam int HIDX_W  = $clog2(HDR_BYTES);

   phase_t              phase;
   logic [HDR_W-1:0]    hdr_q;
   logic [HIDX_W-1:0]   hdr_idx;
   logic [LEN_W-1:0]    data_left;
   logic [3:0]          pad_left;
   logic [3:0]          new_pad;
   logic [LEN_W:0]      new_padded;
   logic                accept;
   logic                fire;
   logic                hdr_done;

   pad_calc #(.ALIGN_BITS(ALIGN_BITS), .LEN_W(LEN_W)) u_pad (
      .len        (req_len),
      .pad_bytes  (new_pad),
      .padded_len (new_padded)
   );

   always_comb begin
      req_ready = running && (phase == PH_IDLE);
      accept    = req_valid && req_ready;
      hdr_done  = (hdr_idx == HIDX_W'(HDR_BYTES - 1));
      unique case (phase)
         PH_HDR:  begin o_valid = 1'b1;     o_data = hdr_q[{hdr_idx, 3'b000} +: 8]; end
         PH_DATA: begin o_valid = pl_valid; o_data = pl_data; end
         PH_PAD:  begin o_valid = 1'b1;     o_data = 8'hFF; end
         default: begin o_valid = 1'b0;     o_data = 8'h00; end
      endcase
      pl_ready = (phase == PH_DATA) && o_ready;
      fire     = o_valid && o_ready;
      unique case (phase)
         PH_HDR:  o_last = hdr_done && (data_left == '0) && (pad_left == '0);
         PH_DATA: o_last = o_valid && (data_left == LEN_W'(1)) && (pad_left == '0);
         PH_PAD:  o_last = (pad_left == 4'd1);
         default: o_last = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         hdr_q     <= '0;
         hdr_idx   <= '0;
         data_left <= '0;
         pad_left  <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (accept) begin
                  hdr_q     <= {SIZE_W'(new_padded), ts_in, req_addr};
                  hdr_idx   <= '0;
                  data_left <= req_len;
                  pad_left  <= new_pad;
                  phase     <= PH_HDR;
               end
            end
            PH_HDR: begin
               if (fire) begin
                  hdr_idx <= hdr_idx + 1'b1;
                  if (hdr_done) begin
                     if (data_left != '0)     phase <= PH_DATA;
                     else if (pad_left != '0) phase <= PH_PAD;
                     else                     phase <= PH_IDLE;
                  end
               end
            end
            PH_DATA: begin
               if (fire) begin
                  data_left <= data_left - 1'b1;
                  if (data_left == LEN_W'(1))
                     phase <= (pad_left != '0) ? PH_PAD : PH_IDLE;
               end
            end
            PH_PAD: begin
               if (fire) begin
                  pad_left <= pad_left - 1'b1;
                  if (pad_left == 4'd1) phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rd_frame_packer.sv
module rd_frame_packer
   import frame_pkg::*;
#(
   parameter int ALIGN_BITS = 32,
   parameter int LEN_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acq_tick,
   input  logic              run_wr_en,
   input  logic              run_wr_val,
   input  logic              cnt_cmd_valid,
   input  logic [1:0]        cnt_cmd,
   output logic              running,
   output logic [63:0]       ts_now,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              pl_valid,
   output logic              pl_ready,
   input  logic [7:0]        pl_data,
   output logic              o_valid,
   input  logic              o_ready,
   output logic [7:0]        o_data,
   output logic              o_last
);
   generate
      if (!(ALIGN_BITS == 8 || ALIGN_BITS == 16 || ALIGN_BITS == 32 || ALIGN_BITS == 64))
      begin : g_bad_align
         $error("ALIGN_BITS must be 8, 16, 32 or 64");
      end
      if (LEN_W < 1 || LEN_W > 31) begin : g_bad_len
         $error("LEN_W must lie in 1..31 so the rounded size fits the size field");
      end
   endgenerate

   acq_timebase #(.CNT_W(TS_W)) u_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .acq_tick   (acq_tick),
      .run_wr_en  (run_wr_en),
      .run_wr_val (run_wr_val),
      .cmd_valid  (cnt_cmd_valid),
      .cmd_code   (cnt_cmd),
      .running    (running),
      .count      (ts_now)
   );

   frame_sequencer #(.ALIGN_BITS(ALIGN_BITS), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .running   (running),
      .ts_in     (ts_now),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .pl_valid  (pl_valid),
      .pl_ready  (pl_ready),
      .pl_data   (pl_data),
      .o_valid   (o_valid),
      .o_ready   (o_ready),
      .o_data    (o_data),
      .o_last    (o_last)
   );
endmodule

// File: rtl/frame_packer_chk.sv
module frame_packer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acq_tick,
   input logic        run_wr_en,
   input logic        cnt_cmd_valid,
   input logic [1:0]  cnt_cmd,
   input logic        running,
   input logic [63:0] ts_now,
   input logic        req_ready,
   input logic        pl_ready,
   input logic        o_valid,
   input logic        o_ready,
   input logic [7:0]  o_data,
   input logic        o_last
);
   logic clr_cmd;
   assign clr_cmd = cnt_cmd_valid && (cnt_cmd == 2'd1 || cnt_cmd == 2'd2);

   p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      running && acq_tick && !clr_cmd |=> ts_now == $past(ts_now) + 64'd1);

   p_ts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !clr_cmd |=> $stable(ts_now));

   p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !req_ready);

   p_clear_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_cmd_valid && cnt_cmd == 2'd1 && !run_wr_en |=> ts_now == 64'd0 && running == $past(running));

   p_clear_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_cmd_valid && cnt_cmd == 2'd2 |=> ts_now == 64'd0 && running);

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && !o_ready |=> o_valid && $stable(o_data));

   p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      o_last |-> o_valid);

   p_pl_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pl_ready |-> o_ready);
endmodule

bind rd_frame_packer frame_packer_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acq_tick      (acq_tick),
   .run_wr_en     (run_wr_en),
   .cnt_cmd_valid (cnt_cmd_valid),
   .cnt_cmd       (cnt_cmd),
   .running       (running),
   .ts_now        (ts_now),
   .req_ready     (req_ready),
   .pl_ready      (pl_ready),
   .o_valid       (o_valid),
   .o_ready       (o_ready),
   .o_data        (o_data),
   .o_last        (o_last)
);

// File: tb/test_rd_frame_packer.sv
`timescale 1ns/1ps
module test_rd_frame_packer;
   localparam int ALIGN_BITS = 32;
   localparam int LEN_W      = 16;
   localparam int AB         = ALIGN_BITS / 8;
   localparam int MAXLEN     = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acq_tick = 1'b0, run_wr_en = 1'b0, run_wr_val = 1'b0;
   logic cnt_cmd_valid = 1'b0;
   logic [1:0] cnt_cmd = 2'd0;
   logic running;
   logic [63:0] ts_now;
   logic req_valid = 1'b0, req_ready;
   logic [31:0] req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic pl_valid = 1'b0, pl_ready;
   logic [7:0] pl_data = '0;
   logic o_valid, o_ready = 1'b0, o_last;
   logic [7:0] o_data;

   int tests = 0, fails = 0;
   bit tick_rand = 1'b0;
   logic [7:0] pl_mem [MAXLEN];
   logic [7:0] got [MAXLEN+24];
   int n_got;
   logic [63:0] exp_ts;

   always #2 clk = ~clk;

   rd_frame_packer #(.ALIGN_BITS(ALIGN_BITS), .LEN_W(LEN_W)) i_rd_frame_packer (
      .clk(clk), .rst_n(rst_n), .acq_tick(acq_tick), .run_wr_en(run_wr_en),
      .run_wr_val(run_wr_val), .cnt_cmd_valid(cnt_cmd_valid), .cnt_cmd(cnt_cmd),
      .running(running), .ts_now(ts_now), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .pl_valid(pl_valid), .pl_ready(pl_ready),
      .pl_data(pl_data), .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
      .o_last(o_last));

   function automatic int padded(int len);
      return ((len + AB - 1) / AB) * AB;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial forever begin
      @(negedge clk);
      if (tick_rand) acq_tick = 1'($urandom % 2);
   end

   task automatic send_req(logic [31:0] a, int len);
      bit acc;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len);
      forever begin
         #1;
         exp_ts = ts_now;
         acc = req_ready;
         @(posedge clk); #1;
         if (acc) break;
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   task automatic feed(int len);
      int idx = 0;
      while (idx < len) begin
         @(negedge clk);
         if (!pl_valid && ($urandom % 4) != 0) begin
            pl_valid = 1'b1; pl_data = pl_mem[idx];
         end
         #1;
         if (pl_valid && pl_ready) begin
            @(posedge clk); #1;
            pl_valid = 1'b0;
            idx++;
         end
      end
   endtask

   task automatic collect();
      bit done = 1'b0, prev_stall = 1'b0;
      logic [7:0] prev_data = '0;
      n_got = 0;
      while (!done) begin
         @(negedge clk);
         o_ready = (($urandom % 4) != 0);
         #1;
         if (prev_stall)
            check(o_valid && o_data == prev_data, "R10 stall hold", longint'(o_data), longint'(prev_data));
         if (o_valid && o_ready) begin
            if (n_got < MAXLEN + 24) got[n_got] = o_data;
            n_got++;
            if (o_last) done = 1'b1;
         end
         prev_stall = o_valid && !o_ready;
         prev_data  = o_data;
      end
   endtask

   task automatic run_frame(logic [31:0] a, int len);
      logic [31:0] f_addr, f_size;
      logic [63:0] f_ts;
      int bad;
      int plen = padded(len);
      for (int i = 0; i < len; i++) pl_mem[i] = 8'($urandom);
      fork
         send_req(a, len);
         feed(len);
         collect();
      join
      check(n_got == 16 + plen, "R3 frame length", n_got, 16 + plen);
      if (n_got == 16 + plen) begin
         f_addr = '0; f_ts = '0; f_size = '0;
         for (int i = 0; i < 4; i++) f_addr[8*i +: 8] = got[i];
         for (int i = 0; i < 8; i++) f_ts[8*i +: 8]   = got[4+i];
         for (int i = 0; i < 4; i++) f_size[8*i +: 8] = got[12+i];
         check(f_addr == a, "R1 address field", f_addr, a);
         check(f_ts == exp_ts, "R5 timestamp field", f_ts, exp_ts);
         check(f_size == 32'(plen), "R2 size field", f_size, plen);
         bad = 0;
         for (int i = 0; i < len; i++) if (got[16+i] != pl_mem[i]) bad++;
         check(bad == 0, "R4 sample bytes", bad, 0);
         bad = 0;
         for (int i = len; i < plen; i++) if (got[16+i] != 8'hFF) bad++;
         check(bad == 0, "R3 pad bytes", bad, 0);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check(running == 1'b0, "R11 running", running, 0);
      check(ts_now == 64'd0, "R11 timestamp", ts_now, 0);
      check(o_valid == 1'b0, "R11 o_valid", o_valid, 0);
      rst_n = 1'b1;

      // R9: stopped, ticks and requests have no effect
      acq_tick = 1'b1; req_valid = 1'b1; req_len = 16'd4;
      repeat (5) begin
         @(negedge clk);
         check(req_ready == 1'b0, "R9 req_ready low", req_ready, 0);
         check(o_valid == 1'b0, "R9 no frame", o_valid, 0);
      end
      check(ts_now == 64'd0, "R9 counter frozen", ts_now, 0);
      req_valid = 1'b0; acq_tick = 1'b0;

      // R6: count while running
      run_wr_en = 1'b1; run_wr_val = 1'b1;
      @(negedge clk); run_wr_en = 1'b0;
      check(running == 1'b1, "R6 running set", running, 1);
      acq_tick = 1'b1; repeat (7) @(negedge clk); acq_tick = 1'b0;
      @(negedge clk);
      check(ts_now == 64'd7, "R6 count", ts_now, 7);

      // R12: codes 0 and 3 ignored
      cnt_cmd_valid = 1'b1; cnt_cmd = 2'd3; @(negedge clk);
      cnt_cmd = 2'd0; @(negedge clk); cnt_cmd_valid = 1'b0;
      @(negedge clk);
      check(ts_now == 64'd7, "R12 count kept", ts_now, 7);
      check(running == 1'b1, "R12 running kept", running, 1);

      // R7: clear keeps running, clear beats tick
      acq_tick = 1'b1; cnt_cmd_valid = 1'b1; cnt_cmd = 2'd1;
      @(negedge clk); cnt_cmd_valid = 1'b0; acq_tick = 1'b0;
      check(ts_now == 64'd0, "R7 cleared", ts_now, 0);
      check(running == 1'b1, "R7 running kept", running, 1);

      // R7 while stopped, then R8 starts
      acq_tick = 1'b1; repeat (3) @(negedge clk);
      run_wr_en = 1'b1; run_wr_val = 1'b0; @(negedge clk); run_wr_en = 1'b0;
      repeat (4) @(negedge clk);
      check(ts_now == 64'd4, "R9 frozen after stop", ts_now, 4);
      cnt_cmd_valid = 1'b1; cnt_cmd = 2'd1; @(negedge clk); cnt_cmd_valid = 1'b0;
      check(ts_now == 64'd0 && running == 1'b0, "R7 stopped clear", {running, ts_now[7:0]}, 0);
      cnt_cmd_valid = 1'b1; cnt_cmd = 2'd2; @(negedge clk); cnt_cmd_valid = 1'b0;
      check(ts_now == 64'd0, "R8 cleared", ts_now, 0);
      check(running == 1'b1, "R8 started", running, 1);
      repeat (3) @(negedge clk);
      check(ts_now == 64'd3, "R6 count after start", ts_now, 3);
      acq_tick = 1'b0;

      // Frames: directed lengths around the word boundary, then random
      tick_rand = 1'b1;
      run_frame(32'hA1B2_C3D4, 0);
      run_frame(32'h0000_0001, 1);
      run_frame(32'h1234_5678, 3);
      run_frame(32'hFFFF_FFFF, 4);
      run_frame(32'h8000_0000, 5);
      run_frame(32'h0BAD_F00D, 8);
      for (int k = 0; k < 12; k++)
         run_frame($urandom, int'($urandom % 41));

      // R9: stopping between frames refuses new requests
      @(negedge clk);
      run_wr_en = 1'b1; run_wr_val = 1'b0; @(negedge clk); run_wr_en = 1'b0;
      req_valid = 1'b1; req_len = 16'd2;
      repeat (4) begin
         @(negedge clk);
         check(req_ready == 1'b0 && o_valid == 1'b0, "R9 stopped refuses", {req_ready, o_valid}, 0);
      end
      req_valid = 1'b0;
      report();
   end
endmodule